// File: doc/BRIEF.md
# Row write buffer with self-timed commit

This block sits between the byte-level engine of a two-wire serial memory slave and its storage array. During a write transaction it gathers up to one row of data bytes (16 by default) in a small staging buffer. The first byte goes to the position given by the low bits of the start address. Each later byte goes to the next position, and the position wraps inside the same row. The upper address bits fixed at the start of the transaction select the row and do not change.

When the engine reports a STOP that fell in the slot right after a data byte's ACK, the block starts one self-timed write cycle. It raises `busy`, drains the loaded positions into the array write port in ascending order, and holds `busy` for a programmable number of clock cycles. It then lowers `busy` and pulses `cycle_done`. While `busy` is high every input from the engine is ignored. The engine uses `busy` to withhold the ACK of a select byte, which is how a master polls for the end of the write. If the write-lock input is seen high at the start of the transaction or with any data byte, nothing is written and no cycle starts.

Top module: `row_commit_buf`

## Requirements
- R1: After reset `busy`, `mem_we` and `cycle_done` are all low.
- R2: Every array write of a commit carries the upper address bits (bits ADDR_W-1 down to 4 by default) of the transaction's start address and the data byte last loaded at that row position.
- R3: Byte k of a transaction (k from 0) is loaded at row position (start_addr[3:0] + k) mod 16, so bytes past position 15 continue at position 0 of the same row.
- R4: A commit writes only the positions loaded in that transaction, one write per cycle in ascending position order, and every write happens while `busy` is high.
- R5: When a later byte of the same transaction lands on an already loaded position, only the later value is written.
- R6: A cycle starts only on a `stop_evt` with `stop_slot_ok` high in an open transaction that loaded at least one byte. A STOP with `stop_slot_ok` low, or after zero bytes, writes nothing and leaves `busy` low.
- R7: Once started, `busy` stays high for exactly WR_CYCLES clock cycles. `cycle_done` is a one-cycle pulse in the first cycle after `busy` falls.
- R8: While `busy` is high, `txn_start`, `byte_stb` and `stop_evt` have no effect. A STOP arriving after the cycle, with no new `txn_start`, starts nothing.
- R9: If `wr_lock` is high together with `txn_start` or with any `byte_stb` of a transaction, that transaction writes nothing and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a write transaction and loads the start address |
| start_addr | input | ADDR_W | Byte address sent at the start of the transaction |
| byte_stb | input | 1 | One received data byte is on `byte_data` |
| byte_data | input | 8 | Data byte |
| wr_lock | input | 1 | Write-protect level from the board |
| stop_evt | input | 1 | STOP detected on the bus |
| stop_slot_ok | input | 1 | The STOP came right after the ACK of a data byte |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| cycle_done | output | 1 | One-cycle pulse when the write cycle ends |

## Verification
Random transactions vary the start offset, the byte count from zero to past a full row, the presence of the STOP slot flag and the moment the lock input rises. Comparing them against a bench row model separates position arithmetic errors from errors in mask handling. Directed runs start at offset 15 so that the wrap shows on the second byte, and send 20 bytes from offset 3 so that overwritten positions must carry the later data. A commit whose busy window is hit with a complete second transaction shows whether inputs leak into the cycle or into the state left behind it.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  typedef enum logic [1:0] {
    FILL_IDLE   = 2'd0,
    FILL_OPEN   = 2'd1,
    FILL_LOCKED = 2'd2
  } fill_state_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/rwb_fill_ctl.sv
module rwb_fill_ctl
  import rwb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 4,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic              wr_lock,
  input  logic              stop_evt,
  input  logic              stop_slot_ok,
  output logic              st_clr,
  output logic              st_wr_en,
  output logic [OFF_W-1:0]  st_wr_idx,
  output logic [ROW_W-1:0]  row_q,
  output logic              commit_req
);
  fill_state_e       state_q;
  logic [OFF_W-1:0]  pos_q;
  logic              loaded_q;
  logic              take_start, take_byte, take_stop;

  assign take_start = txn_start & ~busy;
  assign take_byte  = byte_stb & ~busy & ~txn_start & (state_q != FILL_IDLE);
  assign take_stop  = stop_evt & ~busy & ~txn_start & ~byte_stb & (state_q != FILL_IDLE);

  assign st_clr     = take_start;
  assign st_wr_en   = take_byte & ~wr_lock & (state_q == FILL_OPEN);
  assign st_wr_idx  = pos_q;
  assign commit_req = take_stop & stop_slot_ok & loaded_q & (state_q == FILL_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FILL_IDLE;
      pos_q    <= '0;
      row_q    <= '0;
      loaded_q <= 1'b0;
    end else if (take_start) begin
      state_q  <= wr_lock ? FILL_LOCKED : FILL_OPEN;
      row_q    <= start_addr[ADDR_W-1:OFF_W];
      pos_q    <= start_addr[OFF_W-1:0];
      loaded_q <= 1'b0;
    end else if (take_byte) begin
      if (wr_lock) begin
        state_q <= FILL_LOCKED;
      end else if (state_q == FILL_OPEN) begin
        pos_q    <= pos_q + 1'b1;
        loaded_q <= 1'b1;
      end
    end else if (take_stop) begin
      state_q <= FILL_IDLE;
    end
  end
endmodule

// File: rtl/rwb_row_store.sv
module rwb_row_store #(
  parameter int ROW_BYTES = 16,
  parameter int DATA_W    = 8,
  localparam int OFF_W    = $clog2(ROW_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic              rd_vld_q,
  output logic [DATA_W-1:0] rd_data_q
);
  logic [DATA_W-1:0]    mem [ROW_BYTES];
  logic [ROW_BYTES-1:0] vmask_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vmask_q  <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_en & vmask_q[rd_idx];
      if (clr)        vmask_q <= '0;
      else if (wr_en) vmask_q[wr_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/rwb_commit_seq.sv
module rwb_commit_seq
  import rwb_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int ROW_BYTES = 16,
  parameter int WR_CYCLES = 250000,
  localparam int OFF_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - OFF_W,
  localparam int CNT_W    = cnt_width(WR_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_req,
  input  logic [ROW_W-1:0]  row_in,
  output logic              busy_q,
  output logic              done_q,
  output logic              rd_en,
  output logic [OFF_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [CNT_W-1:0] DRAIN_END = CNT_W'(ROW_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign rd_en  = busy_q & (cnt_q < DRAIN_END);
  assign rd_idx = cnt_q[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (commit_req) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (rd_en) addr_q <= {row_in, rd_idx};
        if (cnt_q == LAST_CNT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_commit_buf.sv
module row_commit_buf #(
  parameter int ADDR_W    = 11,
  parameter int ROW_BYTES = 16,
  parameter int WR_CYCLES = 250000,
  localparam int OFF_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              wr_lock,
  input  logic              stop_evt,
  input  logic              stop_slot_ok,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              cycle_done
);
  logic              st_clr, st_wr_en, commit_req, rd_en;
  logic [OFF_W-1:0]  st_wr_idx, rd_idx;
  logic [ROW_W-1:0]  row_q;

  rwb_fill_ctl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fill (
    .clk(clk), .rst(rst), .busy(busy),
    .txn_start(txn_start), .start_addr(start_addr),
    .byte_stb(byte_stb), .wr_lock(wr_lock),
    .stop_evt(stop_evt), .stop_slot_ok(stop_slot_ok),
    .st_clr(st_clr), .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx),
    .row_q(row_q), .commit_req(commit_req)
  );

  rwb_row_store #(.ROW_BYTES(ROW_BYTES), .DATA_W(8)) u_store (
    .clk(clk), .rst(rst), .clr(st_clr),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_data(byte_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_vld_q(mem_we), .rd_data_q(mem_wdata)
  );

  rwb_commit_seq #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .commit_req(commit_req), .row_in(row_q),
    .busy_q(busy), .done_q(cycle_done),
    .rd_en(rd_en), .rd_idx(rd_idx), .addr_q(mem_addr)
  );
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker #(
  parameter int ADDR_W    = 11,
  parameter int ROW_BYTES = 16,
  parameter int WR_CYCLES = 250000,
  localparam int OFF_W    = $clog2(ROW_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_evt,
  input logic              stop_slot_ok,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              cycle_done
);
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_we && !cycle_done));

  p_same_row_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

  p_write_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_ascending_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])));

  p_start_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_evt && stop_slot_ok));

  p_done_edge_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (!busy && $past(busy)));

  p_busy_length_r7: assert property (@(posedge clk) disable iff (rst)
    cycle_done |-> (busy_len == WR_CYCLES));
endmodule

bind row_commit_buf rwb_checker #(
  .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .stop_evt(stop_evt), .stop_slot_ok(stop_slot_ok),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy), .cycle_done(cycle_done)
);

// File: tb/sim_row_commit_buf.sv
module sim_row_commit_buf;
  localparam int AW = 11;
  localparam int RB = 16;
  localparam int WC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          txn_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_stb = 1'b0;
  logic [7:0]    byte_data = '0;
  logic          wr_lock = 1'b0;
  logic          stop_evt = 1'b0;
  logic          stop_slot_ok = 1'b0;
  logic          mem_we, busy, cycle_done;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int vectors = 0;
  int miscompares = 0;

  logic [AW-1:0] wa [64];
  logic [7:0]    wd [64];
  int wn = 0;
  int done_n = 0;
  int busy_run = 0;
  int last_len = 0;

  row_commit_buf #(.ADDR_W(AW), .ROW_BYTES(RB), .WR_CYCLES(WC)) u0 (
    .clk(clk), .rst(rst), .txn_start(txn_start), .start_addr(start_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .wr_lock(wr_lock),
    .stop_evt(stop_evt), .stop_slot_ok(stop_slot_ok),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .cycle_done(cycle_done)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we && wn < 64) begin
        wa[wn] = mem_addr;
        wd[wn] = mem_wdata;
        wn = wn + 1;
      end
      if (busy) busy_run = busy_run + 1;
      if (cycle_done) begin
        done_n   = done_n + 1;
        last_len = busy_run;
        busy_run = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [AW-1:0] a, input bit lock);
    txn_start = 1'b1; start_addr = a; wr_lock = lock;
    @(posedge clk); #1;
    txn_start = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d, input bit lock);
    byte_stb = 1'b1; byte_data = d; wr_lock = lock;
    @(posedge clk); #1;
    byte_stb = 1'b0; wr_lock = 1'b0;
  endtask

  task automatic do_stop(input bit ok);
    stop_evt = 1'b1; stop_slot_ok = ok;
    @(posedge clk); #1;
    stop_evt = 1'b0; stop_slot_ok = 1'b0;
  endtask

  function automatic int popcnt(input logic [RB-1:0] v);
    int c = 0;
    for (int i = 0; i < RB; i++) c += v[i];
    return c;
  endfunction

  // One transaction, compared against a row model built here.
  task automatic run_txn(input logic [AW-1:0] a, input int n, input bit lock_start,
                         input int lock_byte, input bit slot, input string tag);
    logic [RB-1:0] ev;
    logic [7:0]    ed [RB];
    int            pos, k;
    bit            prot, commit;
    ev = '0; wn = 0; done_n = 0;
    prot = lock_start;
    pos = int'(a[3:0]);
    do_start(a, lock_start);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (i == lock_byte) prot = 1'b1;
      ed[pos] = d; ev[pos] = 1'b1;
      pos = (pos + 1) % RB;
      do_byte(d, i == lock_byte);
      if ($urandom_range(3) == 0) begin @(posedge clk); #1; end
    end
    do_stop(slot);
    commit = slot && (n > 0) && !prot;
    repeat (WC + 6) @(posedge clk);
    #1;
    check(done_n == (commit ? 1 : 0), {tag, " R6 R9 cycle started"}, done_n, commit ? 1 : 0);
    if (!commit) begin
      check(wn == 0, {tag, " R6 R9 no writes"}, wn, 0);
    end else begin
      check(last_len == WC, {tag, " R7 busy length"}, last_len, WC);
      check(wn == popcnt(ev), {tag, " R4 write count"}, wn, popcnt(ev));
      k = 0;
      for (int p = 0; p < RB; p++) begin
        if (ev[p] && k < wn) begin
          check(wa[k] == {a[AW-1:4], 4'(p)}, {tag, " R2 R3 write address"}, int'(wa[k]),
                int'({a[AW-1:4], 4'(p)}));
          check(wd[k] == ed[p], {tag, " R2 R5 write data"}, int'(wd[k]), int'(ed[p]));
          k++;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !mem_we && !cycle_done, "R1 reset outputs", {busy, mem_we, cycle_done}, 0);
    @(posedge clk); #1;

    run_txn(11'h230, 1, 1'b0, -1, 1'b1, "R2 single byte");
    run_txn(11'h14F, 3, 1'b0, -1, 1'b1, "R3 wrap at 15");
    run_txn(11'h503, 20, 1'b0, -1, 1'b1, "R5 overwrite");
    run_txn(11'h7F0, 16, 1'b0, -1, 1'b1, "R4 full row");
    run_txn(11'h0A5, 4, 1'b0, -1, 1'b0, "R6 slot low");
    run_txn(11'h0A5, 0, 1'b0, -1, 1'b1, "R6 zero bytes");
    run_txn(11'h311, 5, 1'b1, -1, 1'b1, "R9 lock at start");
    run_txn(11'h311, 5, 1'b0, 3, 1'b1, "R9 lock mid");

    // R8: a full transaction pushed into the busy window
    wn = 0; done_n = 0;
    do_start(11'h123, 1'b0);
    do_byte(8'h5A, 1'b0);
    do_byte(8'hC3, 1'b0);
    do_stop(1'b1);
    repeat (3) @(posedge clk); #1;
    do_start(11'h200, 1'b0);
    do_byte(8'h11, 1'b0);
    do_byte(8'h22, 1'b0);
    do_byte(8'h33, 1'b0);
    do_stop(1'b1);
    repeat (WC + 6) @(posedge clk); #1;
    check(done_n == 1, "R8 one cycle only", done_n, 1);
    check(wn == 2, "R8 write count", wn, 2);
    check(wn == 2 && wa[1] == 11'h124 && wd[1] == 8'hC3, "R8 second write", int'(wd[1]), 8'hC3);
    do_stop(1'b1);
    repeat (WC + 6) @(posedge clk); #1;
    check(done_n == 1 && wn == 2, "R8 stray stop after cycle", done_n, 1);

    for (int t = 0; t < 24; t++) begin
      logic [AW-1:0] a;
      int  n, lb;
      bit  ls, sl;
      a  = AW'($urandom);
      n  = $urandom_range(20);
      ls = ($urandom_range(7) == 0);
      lb = ($urandom_range(5) == 0) ? $urandom_range(19) : -1;
      sl = ($urandom_range(5) != 0);
      run_txn(a, n, ls, lb, sl, "R3 R4 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule